// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block decides when the CPU, the peripherals and the oscillator of a small microcontroller may be clocked. Software requests a light sleep, in which only the CPU clock stops, or a deep sleep, in which the oscillator and every clock stop. The controller runs on an always-on clock and watches two active-low external interrupt pins and an external reset pin. It reopens the clocks when a wake condition is met and flags the waking interrupt for service.

A deep sleep can end in three ways. A qualifying interrupt can start a fixed wake-up timeout. A qualifying interrupt can instead hold the wake period open until the pin returns high. A reset pulse runs the same timeout and then waits for the reset to be released. After any reset or any exit from deep sleep, a guard window refuses new deep-sleep requests. The wake timeout and the guard window are cycle-count parameters. All pins are control pins with no stream handshake. Request inputs are one-cycle write strobes, and the mode bits clear themselves when the controller leaves the mode.

Top module: `lpw_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1 and `svc_req` is 0.
- R2: A deep-sleep strobe that is accepted drives all three enables to 0 on the next clock edge. If both strobes arrive together, deep sleep wins, and an accepted request gives `per_clk_en` = 0.
- R3: A light-sleep strobe drives `cpu_clk_en` to 0 on the next edge and keeps `per_clk_en` and `osc_en` at 1.
- R4: Light sleep ends when an enabled interrupt fires or the reset pin goes high. An interrupt fires on a low level when `int_edge[i]`=0 and on a falling edge when `int_edge[i]`=1. `cpu_clk_en` returns 3 clock edges after the pin change. An interrupt exit sets `svc_req[i]` for exactly that first cycle, and a reset exit sets no bit. A disabled interrupt has no effect.
- R5: In deep sleep, only a falling edge on a pin with `int_en[i]`=1 and `int_edge[i]`=0 wakes the block. Any other pin activity leaves all enables at 0.
- R6: With `wake_ext`=0, a qualifying fall raises `osc_en` 3 edges after the pin falls and `cpu_clk_en` TIMEOUT_CYC+3 edges after it. `svc_req[i]` is 1 in that first running cycle.
- R7: With `wake_ext`=1, a qualifying fall raises `osc_en` 3 edges later. `cpu_clk_en` stays 0 until 3 edges after the waking pin returns high, and `svc_req[i]` is 1 in that cycle.
- R8: A rising reset pin during deep sleep raises `osc_en` 3 edges later. `cpu_clk_en` stays 0 until the timeout has elapsed and the reset pin has fallen, and it rises 3 edges after the fall when the pin was held past the timeout. No `svc_req` bit is set.
- R9: For GUARD_CYC cycles after `rst_n` release, after the reset pin falls, and after each deep-sleep exit, a deep-sleep strobe is refused. A refused strobe, even one paired with a light-sleep strobe, leaves every enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| idle_wr | input | 1 | Light-sleep request strobe |
| pd_wr | input | 1 | Deep-sleep request strobe |
| wake_ext | input | 1 | Deep-sleep wake mode: 0 = timed, 1 = held by pin |
| int_n | input | NUM_INT | External interrupt pins, active low, asynchronous |
| int_en | input | NUM_INT | Interrupt enables |
| int_edge | input | NUM_INT | Trigger select: 1 = falling edge, 0 = low level |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| svc_req | output | NUM_INT | One-cycle request to service the waking interrupt |

## Verification
The assertions assume that the request strobes, `wake_ext`, `int_en` and `int_edge` are synchronous to `clk` and held steady while the block sleeps. They also assume that a pin holding a deep-sleep wake open returns high. The stimulus changes configuration only while the CPU runs and drives every input on the falling clock edge. Randomised deep-sleep trials release the waking pin in hold mode and bring any block left asleep back through the reset pin. Pins are left high for several cycles before each sleep, so that a stale edge cannot count as a wake event.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_PD,
    ST_PD_TMR,
    ST_PD_HOLD,
    ST_RST_TMR,
    ST_RST_WAIT
  } lpw_state_e;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpw_downcnt.sv
module lpw_downcnt #(
  parameter int MAXV = 16,
  parameter int LOADV = 16,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= CW'(LOADV);
    else if (load)               cnt <= CW'(LOADV);
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_CNT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R6
endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
  import lpw_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int GUARD_CYC = 8,
  parameter int NUM_INT = 2,
  localparam int TMR_LOAD = (TIMEOUT_CYC > 0) ? TIMEOUT_CYC - 1 : 0,
  localparam int SW = NUM_INT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_pin,
  input  logic               idle_wr,
  input  logic               pd_wr,
  input  logic               wake_ext,
  input  logic [NUM_INT-1:0] int_n,
  input  logic [NUM_INT-1:0] int_en,
  input  logic [NUM_INT-1:0] int_edge,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en,
  output logic [NUM_INT-1:0] svc_req
);
  lpw_state_e st, nxt;
  logic [NUM_INT-1:0] int_s, int_prev, fall_v, idle_evt, pd_evt;
  logic [NUM_INT-1:0] wsrc_q, wsrc_nxt, svc_nxt;
  logic rst_s, rst_prev, rst_rise, pins_hi;
  logic tmr_load, tmr_zero, grd_load, grd_zero, pd_exit;
  logic [SW-1:0] sync_q;

  lpw_sync #(.W(SW), .STAGES(2), .RST_VAL({1'b0, {NUM_INT{1'b1}}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rst_pin, int_n}), .q(sync_q)
  );
  assign int_s = sync_q[NUM_INT-1:0];
  assign rst_s = sync_q[NUM_INT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_prev <= '1;
      rst_prev <= 1'b0;
    end else begin
      int_prev <= int_s;
      rst_prev <= rst_s;
    end
  end

  assign rst_rise = rst_s & ~rst_prev;
  assign fall_v   = int_prev & ~int_s;

  generate
    for (genvar i = 0; i < NUM_INT; i++) begin : g_evt
      assign idle_evt[i] = int_en[i] & (int_edge[i] ? fall_v[i] : ~int_s[i]);
      assign pd_evt[i]   = int_en[i] & ~int_edge[i] & fall_v[i];
    end
  endgenerate

  assign pins_hi = &(int_s | ~wsrc_q);

  always_comb begin
    nxt      = st;
    svc_nxt  = '0;
    wsrc_nxt = wsrc_q;
    unique case (st)
      ST_RUN: begin
        if (pd_wr) begin
          if (grd_zero && !rst_s) nxt = ST_PD;
        end else if (idle_wr && !rst_s) begin
          nxt = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (rst_s) nxt = ST_RUN;
        else if (|idle_evt) begin
          nxt     = ST_RUN;
          svc_nxt = idle_evt;
        end
      end
      ST_PD: begin
        if (rst_rise) nxt = ST_RST_TMR;
        else if (|pd_evt) begin
          wsrc_nxt = pd_evt;
          nxt      = wake_ext ? ST_PD_HOLD : ST_PD_TMR;
        end
      end
      ST_PD_TMR: begin
        if (rst_rise) nxt = ST_RST_TMR;
        else if (tmr_zero) begin
          nxt     = ST_RUN;
          svc_nxt = wsrc_q;
        end
      end
      ST_PD_HOLD: begin
        if (rst_rise) nxt = ST_RST_TMR;
        else if (pins_hi) begin
          nxt     = ST_RUN;
          svc_nxt = wsrc_q;
        end
      end
      ST_RST_TMR:  if (tmr_zero) nxt = ST_RST_WAIT;
      ST_RST_WAIT: if (!rst_s) nxt = ST_RUN;
      default:     nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      svc_req <= '0;
      wsrc_q  <= '0;
    end else begin
      st      <= nxt;
      svc_req <= svc_nxt;
      wsrc_q  <= wsrc_nxt;
    end
  end

  assign tmr_load = ((nxt == ST_PD_TMR) && (st != ST_PD_TMR)) ||
                    ((nxt == ST_RST_TMR) && (st != ST_RST_TMR));

  lpw_downcnt #(.MAXV(TMR_LOAD), .LOADV(TMR_LOAD)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .dec(1'b1), .zero(tmr_zero)
  );

  assign pd_exit  = (st inside {ST_PD_TMR, ST_PD_HOLD, ST_RST_WAIT}) && (nxt == ST_RUN);
  assign grd_load = rst_s | pd_exit;

  lpw_downcnt #(.MAXV(GUARD_CYC), .LOADV(GUARD_CYC)) u_grd (
    .clk(clk), .rst_n(rst_n), .load(grd_load), .dec(1'b1), .zero(grd_zero)
  );

  assign cpu_clk_en = (st == ST_RUN);
  assign per_clk_en = (st == ST_RUN) || (st == ST_IDLE);
  assign osc_en     = (st != ST_PD);

  AST_OSC_OFF_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(pd_wr)); // R2
  AST_SVC_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req) |-> cpu_clk_en); // R4
  AST_PD_NO_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD && !(|pd_evt) && !rst_rise) |=> !osc_en); // R5
  AST_TMR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD_TMR && !tmr_zero) |=> !cpu_clk_en); // R6
  AST_HOLD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD_HOLD && !pins_hi) |=> !cpu_clk_en); // R7
  AST_RST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RST_WAIT && rst_s) |=> !cpu_clk_en); // R8
  AST_PD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && pd_wr && !grd_zero) |=> (osc_en && cpu_clk_en)); // R9
endmodule

// File: tb/sim_lpw_ctrl.sv
module sim_lpw_ctrl;
  localparam int T = 16;
  localparam int G = 8;

  logic clk = 1'b0;
  logic rst_n, rst_pin, idle_wr, pd_wr, wake_ext;
  logic [1:0] int_n, int_en, int_edge, svc_req;
  logic cpu_clk_en, per_clk_en, osc_en;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpw_ctrl #(.TIMEOUT_CYC(T), .GUARD_CYC(G), .NUM_INT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_wr(idle_wr), .pd_wr(pd_wr),
    .wake_ext(wake_ext), .int_n(int_n), .int_en(int_en), .int_edge(int_edge),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en), .svc_req(svc_req)
  );

  function automatic bit exp_wake(bit en, bit edg);
    return en && !edg;
  endfunction

  function automatic int exp_cpu_lat(bit hold_mode);
    return hold_mode ? 3 : T + 3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit i, bit p);
    idle_wr = i; pd_wr = p;
    step();
    idle_wr = 0; pd_wr = 0;
  endtask

  task automatic first_cpu(int lim, output int k);
    k = 0;
    while (!cpu_clk_en && k <= lim) begin step(); k++; end
  endtask

  task automatic first_osc(int lim, output int k);
    k = 0;
    while (!osc_en && k <= lim) begin step(); k++; end
  endtask

  task automatic recover_by_reset();
    int ko, kc, bad;
    rst_pin = 1;
    first_osc(10, ko);
    chk(ko == 3, "R8 osc restart", ko, 3);
    bad = 0;
    for (int i = 0; i < T + 5; i++) begin step(); if (cpu_clk_en) bad++; end
    chk(bad == 0, "R8 cpu gated while reset held", bad, 0);
    rst_pin = 0;
    first_cpu(10, kc);
    chk(kc == 3, "R8 resume after reset low", kc, 3);
    chk(svc_req == 2'b00, "R8 no svc", svc_req, 0);
    step(G + 4);
  endtask

  task automatic pd_trial(int src, bit en, bit edg, bit mode);
    int ko, kc, bad, h;
    int_en = '0; int_edge = '0;
    int_en[src] = en; int_edge[src] = edg; wake_ext = mode;
    int_n = 2'b11;
    step(G + 4);
    strobe(0, 1);
    chk(!osc_en && !cpu_clk_en && !per_clk_en, "R2 deep sleep enables",
        {osc_en, cpu_clk_en, per_clk_en}, 0);
    int_n[src] = 0;
    if (exp_wake(en, edg)) begin
      if (!mode) begin
        ko = -1; kc = -1;
        for (int k = 1; k <= T + 10 && kc < 0; k++) begin
          step();
          if (osc_en && ko < 0) ko = k;
          if (cpu_clk_en) kc = k;
        end
        chk(ko == 3, "R6 osc restart", ko, 3);
        chk(kc == exp_cpu_lat(0), "R6 cpu after timeout", kc, exp_cpu_lat(0));
      end else begin
        step(3);
        chk(osc_en && !cpu_clk_en, "R7 osc on cpu gated", {osc_en, cpu_clk_en}, 2);
        h = 2 + int'($urandom % T);
        bad = 0;
        for (int i = 0; i < h; i++) begin step(); if (cpu_clk_en) bad++; end
        chk(bad == 0, "R7 cpu gated while pin low", bad, 0);
        int_n[src] = 1;
        first_cpu(10, kc);
        chk(kc == exp_cpu_lat(1), "R7 cpu after pin release", kc, exp_cpu_lat(1));
      end
      chk(svc_req == (2'b01 << src), mode ? "R7 svc flag" : "R6 svc flag",
          svc_req, 2'b01 << src);
      int_n = 2'b11;
      strobe(0, 1);
      chk(osc_en && cpu_clk_en, "R9 refused after deep-sleep exit", {osc_en, cpu_clk_en}, 3);
      step(G + 4);
    end else begin
      bad = 0;
      for (int i = 0; i < T + 8; i++) begin step(); if (osc_en || cpu_clk_en) bad++; end
      chk(bad == 0, "R5 non-qualifying pin ignored", bad, 0);
      int_n = 2'b11;
      step(3);
      recover_by_reset();
    end
  endtask

  initial begin
    int k, bad;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 0; rst_pin = 0; idle_wr = 0; pd_wr = 0; wake_ext = 0;
    int_n = 2'b11; int_en = 0; int_edge = 0;
    step(4);
    rst_n = 1;
    step();
    chk(cpu_clk_en && per_clk_en && osc_en && svc_req == 0, "R1 reset state",
        {cpu_clk_en, per_clk_en, osc_en, svc_req}, 5'b11100);
    strobe(1, 1);
    chk(osc_en && cpu_clk_en && per_clk_en, "R9 refused after power-on",
        {osc_en, cpu_clk_en, per_clk_en}, 7);
    step(G + 4);

    // light sleep, level-mode int1
    int_en = 2'b10; int_edge = 2'b00;
    strobe(1, 0);
    chk(!cpu_clk_en && per_clk_en && osc_en, "R3 light sleep enables",
        {cpu_clk_en, per_clk_en, osc_en}, 3);
    int_n[1] = 0;
    first_cpu(10, k);
    chk(k == 3, "R4 level exit latency", k, 3);
    chk(svc_req == 2'b10, "R4 svc on first cycle", svc_req, 2);
    step();
    chk(svc_req == 2'b00, "R4 svc single cycle", svc_req, 0);
    int_n = 2'b11; step(3);

    // disabled pin ignored, then reset exit from light sleep
    int_en = 2'b10;
    strobe(1, 0);
    int_n[0] = 0;
    bad = 0;
    for (int i = 0; i < 8; i++) begin step(); if (cpu_clk_en) bad++; end
    chk(bad == 0, "R4 disabled interrupt ignored", bad, 0);
    rst_pin = 1;
    first_cpu(10, k);
    chk(k == 3 && svc_req == 0, "R4 reset ends light sleep", k, 3);
    rst_pin = 0; int_n = 2'b11; step(G + 4);

    // light sleep, edge-mode int0
    int_en = 2'b01; int_edge = 2'b01;
    strobe(1, 0);
    int_n[0] = 0;
    first_cpu(10, k);
    chk(k == 3 && svc_req == 2'b01, "R4 edge exit", k, 3);
    int_n = 2'b11; step(3);

    // both strobes: deep sleep wins
    step(G + 4);
    strobe(1, 1);
    chk(!per_clk_en && !osc_en, "R2 deep sleep wins", {per_clk_en, osc_en}, 0);
    recover_by_reset();

    // directed deep-sleep corners
    pd_trial(0, 1, 0, 0);
    pd_trial(1, 1, 0, 1);
    pd_trial(0, 1, 1, 0);
    pd_trial(1, 0, 0, 0);

    // random deep-sleep trials
    for (int n = 0; n < 24; n++)
      pd_trial(int'($urandom % 2), 1'($urandom), 1'($urandom % 3 == 0), 1'($urandom));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule